// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator

This block takes a single PWM logic level and produces two gate-enable signals for a half-bridge: one for the high-side switch, which follows the PWM level, and one for the low-side switch, which follows its complement. Each time the PWM level changes, the block turns the conducting side off at once. It then waits a dead-time interval with both enables low before it turns the other side on.

The dead-time length is taken from an 8-bit mode code. The code is the voltage on a divider pin, expressed as a fraction of the supply, with 255 standing for the full supply. The code falls into one of four bands, and each band selects one of four interval lengths. A code below the lowest band boundary is a shutdown request.

A supply-level code, at 0.1 V per step, drives an undervoltage lockout with hysteresis. While the lockout is active, or while shutdown is requested, both enables are held low. When either inhibit clears, a full dead-time interval passes with both enables low before the first turn-on.

Top module: `hb_deadtime_gen`

## Requirements
- R1: Outside dead-time gaps, `gate_hi_o` equals the PWM level and `gate_lo_o` equals its complement. The conducting output drops in the first cycle after the PWM edge is sampled.
- R2: `gate_hi_o` and `gate_lo_o` are never high in the same cycle.
- R3: The number of cycles with both outputs low between a PWM edge and the turn-on of the other side depends on the mode code. A code of 227 or more gives 3 cycles. A code from 145 to 226 gives 5. A code from 92 to 144 gives 7. A code from 59 to 91 gives 9.
- R4: The dead time has the same length for a rising PWM edge and for a falling PWM edge.
- R5: A mode code of 58 or less forces both outputs low from the first cycle after it is sampled, whatever the PWM does.
- R6: The lockout asserts when the supply code falls below 82 and releases when the supply code rises above 90. Inside the range 82 to 90 it keeps its previous state.
- R7: While the lockout is active, both outputs are low. They go low within two cycles of the sample that trips the lockout.
- R8: If the PWM level returns to its previous value before a dead time completes, the pending turn-on is cancelled and a new full dead time is counted toward the new level.
- R9: After shutdown or lockout clears, both outputs stay low for at least one full dead time before either turns on.
- R10: During and right after reset, both outputs are low and the lockout is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_i | input | 1 | PWM logic level; high requests the high side |
| mode_code_i | input | 8 | Mode pin voltage as a fraction of the supply, 255 = full supply |
| supply_code_i | input | 8 | Supply level at 0.1 V per step |
| gate_hi_o | output | 1 | High-side gate enable |
| gate_lo_o | output | 1 | Low-side gate enable |

## Verification
The assertions assume that all three inputs are synchronous to the clock and stable around its rising edge. They also assume that the mode and supply codes are held for at least one cycle after a change. The stimulus changes every input only at falling edges and holds each mode code long enough to settle, or long enough to cut off a dead time in progress on purpose. The PWM input is left unconstrained, so pulses shorter than any dead time are driven in order to exercise the cancel path.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

    // Phase of the bridge sequencer
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,  // inhibited, both off
        PH_GAP  = 2'd1,  // both off, counting toward target side
        PH_HIGH = 2'd2,  // high side conducting
        PH_LOW  = 2'd3   // low side conducting
    } bridge_phase_e;

    localparam int unsigned NUM_BANDS = 4;

endpackage

// File: rtl/hb_mode_decode.sv
module hb_mode_decode #(
    parameter int unsigned CODE_W  = 8,
    parameter int unsigned CNT_W   = 4,
    parameter int unsigned EDGE_0  = 227,
    parameter int unsigned EDGE_1  = 145,
    parameter int unsigned EDGE_2  = 92,
    parameter int unsigned EDGE_3  = 59,
    parameter int unsigned LEN_0   = 3,
    parameter int unsigned LEN_1   = 5,
    parameter int unsigned LEN_2   = 7,
    parameter int unsigned LEN_3   = 9
) (
    input  logic [CODE_W-1:0] code_i,
    output logic              halt_o,
    output logic [CNT_W-1:0]  gap_len_o
);
    import hb_dt_pkg::*;

    localparam int unsigned EDGES [NUM_BANDS] = '{EDGE_0, EDGE_1, EDGE_2, EDGE_3};
    localparam int unsigned LENS  [NUM_BANDS] = '{LEN_0, LEN_1, LEN_2, LEN_3};

    logic [NUM_BANDS-1:0] above;

    genvar g;
    generate
        for (g = 0; g < NUM_BANDS; g++) begin : g_cmp
            assign above[g] = (code_i >= CODE_W'(EDGES[g]));
        end
    endgenerate

    always_comb begin
        gap_len_o = CNT_W'(LENS[NUM_BANDS-1]);
        // walk from the longest band to the shortest; highest matching band wins
        for (int i = NUM_BANDS - 1; i >= 0; i--) begin
            if (above[i]) begin
                gap_len_o = CNT_W'(LENS[i]);
            end
        end
        halt_o = ~above[NUM_BANDS-1];
    end

endmodule

// File: rtl/hb_uvlo.sv
module hb_uvlo #(
    parameter int unsigned LVL_W    = 8,
    parameter int unsigned TRIP_LVL = 82,
    parameter int unsigned FREE_LVL = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] level_i,
    output logic             lock_o
);
    logic lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (lock_q) begin
            if (level_i > LVL_W'(FREE_LVL)) lock_d = 1'b0;
        end else begin
            if (level_i < LVL_W'(TRIP_LVL)) lock_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= 1'b1;
        else        lock_q <= lock_d;
    end

    assign lock_o = lock_q;

    AST_UV_STAYS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_q && level_i >= LVL_W'(TRIP_LVL)) |=> !lock_q); // R6
    AST_UV_STAYS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && level_i <= LVL_W'(FREE_LVL)) |=> lock_q); // R6

endmodule

// File: rtl/hb_gap_seq.sv
module hb_gap_seq #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwm_i,
    input  logic             inhibit_i,
    input  logic [CNT_W-1:0] gap_len_i,
    output logic             hi_o,
    output logic             lo_o
);
    import hb_dt_pkg::*;

    typedef struct packed {
        bridge_phase_e    phase;
        logic             goal;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (inhibit_i) begin
            s_d.phase = PH_IDLE;
            s_d.cnt   = '0;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase = PH_GAP;
                    s_d.goal  = pwm_i;
                    s_d.cnt   = CNT_W'(1);
                end
                PH_GAP: begin
                    if (pwm_i != s_q.goal) begin
                        s_d.goal = pwm_i;           // cancel, restart count
                        s_d.cnt  = CNT_W'(1);
                    end else if (s_q.cnt >= gap_len_i) begin
                        s_d.phase = pwm_i ? PH_HIGH : PH_LOW;
                        s_d.cnt   = '0;
                    end else begin
                        s_d.cnt = s_q.cnt + CNT_W'(1);
                    end
                end
                PH_HIGH: begin
                    if (!pwm_i) begin
                        s_d.phase = PH_GAP;
                        s_d.goal  = 1'b0;
                        s_d.cnt   = CNT_W'(1);
                    end
                end
                PH_LOW: begin
                    if (pwm_i) begin
                        s_d.phase = PH_GAP;
                        s_d.goal  = 1'b1;
                        s_d.cnt   = CNT_W'(1);
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.phase <= PH_IDLE;
            s_q.goal  <= 1'b0;
            s_q.cnt   <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign hi_o = (s_q.phase == PH_HIGH);
    assign lo_o = (s_q.phase == PH_LOW);

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o)); // R2
    AST_HI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_o && !pwm_i) |=> !hi_o); // R1
    AST_LO_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_o && pwm_i) |=> !lo_o); // R1
    AST_INHIBIT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        inhibit_i |=> (!hi_o && !lo_o)); // R5 R7
    AST_CANCEL_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_GAP && pwm_i != s_q.goal) |=> (!hi_o && !lo_o)); // R8
    AST_LEAVE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.phase == PH_IDLE) |=> (!hi_o && !lo_o)); // R9

endmodule

// File: rtl/hb_deadtime_gen.sv
module hb_deadtime_gen #(
    parameter int unsigned CODE_W   = 8,
    parameter int unsigned EDGE_0   = 227,
    parameter int unsigned EDGE_1   = 145,
    parameter int unsigned EDGE_2   = 92,
    parameter int unsigned EDGE_3   = 59,
    parameter int unsigned LEN_0    = 3,
    parameter int unsigned LEN_1    = 5,
    parameter int unsigned LEN_2    = 7,
    parameter int unsigned LEN_3    = 9,
    parameter int unsigned LVL_W    = 8,
    parameter int unsigned TRIP_LVL = 82,
    parameter int unsigned FREE_LVL = 90
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_i,
    input  logic [CODE_W-1:0] mode_code_i,
    input  logic [LVL_W-1:0]  supply_code_i,
    output logic              gate_hi_o,
    output logic              gate_lo_o
);
    localparam int unsigned MAX_LEN = (LEN_3 > LEN_2 ? (LEN_3 > LEN_1 ? (LEN_3 > LEN_0 ? LEN_3 : LEN_0)
                                      : (LEN_1 > LEN_0 ? LEN_1 : LEN_0))
                                      : (LEN_2 > LEN_1 ? (LEN_2 > LEN_0 ? LEN_2 : LEN_0)
                                      : (LEN_1 > LEN_0 ? LEN_1 : LEN_0)));
    localparam int unsigned CNT_W   = $clog2(MAX_LEN + 2);

    logic             halt;
    logic             lock;
    logic [CNT_W-1:0] gap_len;

    hb_mode_decode #(
        .CODE_W(CODE_W), .CNT_W(CNT_W),
        .EDGE_0(EDGE_0), .EDGE_1(EDGE_1), .EDGE_2(EDGE_2), .EDGE_3(EDGE_3),
        .LEN_0(LEN_0), .LEN_1(LEN_1), .LEN_2(LEN_2), .LEN_3(LEN_3)
    ) u_decode (
        .code_i    (mode_code_i),
        .halt_o    (halt),
        .gap_len_o (gap_len)
    );

    hb_uvlo #(
        .LVL_W(LVL_W), .TRIP_LVL(TRIP_LVL), .FREE_LVL(FREE_LVL)
    ) u_uvlo (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (supply_code_i),
        .lock_o  (lock)
    );

    hb_gap_seq #(
        .CNT_W(CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwm_i     (pwm_i),
        .inhibit_i (halt | lock),
        .gap_len_i (gap_len),
        .hi_o      (gate_hi_o),
        .lo_o      (gate_lo_o)
    );

    AST_LOCK_BLOCKS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (!gate_hi_o && !gate_lo_o) || $fell(lock) || $rose(lock)); // R7

endmodule

// File: tb/sim_hb_deadtime_gen.sv
`timescale 1ns/1ps
module sim_hb_deadtime_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm = 1'b0;
    logic [7:0] mode = 8'd240;
    logic [7:0] sup = 8'd120;
    logic       hi, lo;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit done  = 0;

    always #4 clk = ~clk;   // 125 MHz

    hb_deadtime_gen u0 (
        .clk(clk), .rst_n(rst_n), .pwm_i(pwm),
        .mode_code_i(mode), .supply_code_i(sup),
        .gate_hi_o(hi), .gate_lo_o(lo)
    );

    // ---------- behavioural reference ----------
    int m_ph  = 0;   // 0 idle, 1 waiting, 2 high on, 3 low on
    int m_wait = 0;
    int m_goal = 0;
    int m_lock = 1;

    function automatic int want_gap(input int c);
        if (c >= 227) return 3;
        if (c >= 145) return 5;
        if (c >= 92)  return 7;
        return 9;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_wait = 0; m_goal = 0; m_lock = 1;
        end else begin
            int p;
            p = int'(pwm);
            if (mode < 59 || m_lock == 1) begin
                m_ph = 0; m_wait = 0;
            end else if (m_ph == 0) begin
                m_ph = 1; m_goal = p; m_wait = 1;
            end else if (m_ph == 1) begin
                if (p != m_goal) begin
                    m_goal = p; m_wait = 1;
                end else if (m_wait >= want_gap(int'(mode))) begin
                    m_ph = (p == 1) ? 2 : 3; m_wait = 0;
                end else begin
                    m_wait++;
                end
            end else if ((m_ph == 2 && p == 0) || (m_ph == 3 && p == 1)) begin
                m_ph = 1; m_goal = p; m_wait = 1;
            end
            if (m_lock == 1 && sup > 90) m_lock = 0;
            else if (m_lock == 0 && sup < 82) m_lock = 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        cyc++;
        if (rst_n && !done) begin
            chk(hi == (m_ph == 2), "R1 hi vs model", int'(hi), int'(m_ph == 2));
            chk(lo == (m_ph == 3), "R1 lo vs model", int'(lo), int'(m_ph == 3));
            chk(!(hi && lo), "R2 overlap", int'(hi & lo), 0);
        end
    end

    // watchdog
    initial begin
        wait (cyc > 100000);
        if (!done) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Drive pwm to v, count both-low cycles until the target side turns on
    task automatic gap_test(input bit v, input int exp, input string tag);
        int gap = 0;
        pwm = v;
        @(negedge clk);
        chk(v ? !lo : !hi, {tag, " R1 drop"}, int'(v ? lo : hi), 0);
        for (int k = 0; k < 40; k++) begin
            if (v ? hi : lo) break;
            if (!hi && !lo) gap++;
            @(negedge clk);
        end
        chk(gap == exp, tag, gap, exp);
        tick(3);
    endtask

    initial begin
        // R10: reset state
        tick(3);
        chk(!hi && !lo, "R10 outputs low in reset", int'({hi, lo}), 0);
        rst_n = 1'b1;
        tick(1);
        chk(!hi && !lo, "R10 outputs low after reset", int'({hi, lo}), 0);
        tick(30);
        chk(lo && !hi, "R1 low side on with pwm low", int'({hi, lo}), 1);

        // R3 / R4: every band, both edges
        begin
            int codes [7] = '{227, 226, 145, 144, 92, 91, 59};
            int gaps  [7] = '{3, 5, 5, 7, 7, 9, 9};
            for (int i = 0; i < 7; i++) begin
                mode = codes[i][7:0];
                tick(2);
                gap_test(1'b1, gaps[i], "R3 rising gap");
                gap_test(1'b0, gaps[i], "R4 falling gap");
            end
            mode = 8'd250;
            tick(2);
            gap_test(1'b1, 3, "R3 top code");
            gap_test(1'b0, 3, "R4 top code");
        end

        // R8: short pulse shorter than the gap is cancelled
        mode = 8'd70;   // 9 cycles
        tick(12);
        begin
            int hi_seen = 0;
            int gap = 0;
            pwm = 1'b1; tick(3);
            pwm = 1'b0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (hi) hi_seen++;
                if (lo) break;
                gap++;
            end
            chk(hi_seen == 0, "R8 cancelled turn-on", hi_seen, 0);
            chk(gap == 9, "R8 restarted gap", gap, 9);
        end
        // glitch train
        for (int k = 0; k < 10; k++) begin
            pwm = ~pwm; tick(1 + (k % 4));
        end
        pwm = 1'b1;
        tick(20);
        chk(hi && !lo, "R8 settles after glitches", int'({hi, lo}), 2);

        // R5: shutdown band
        mode = 8'd58;
        tick(1);
        chk(!hi && !lo, "R5 shutdown off", int'({hi, lo}), 0);
        for (int k = 0; k < 6; k++) begin
            pwm = ~pwm; tick(3);
            chk(!hi && !lo, "R5 shutdown holds", int'({hi, lo}), 0);
        end
        // R9: leaving shutdown
        pwm = 1'b1;
        mode = 8'd150;  // 5 cycles
        begin
            int gap = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (hi) break;
                gap++;
            end
            chk(gap >= 5, "R9 gap after shutdown", gap, 5);
            chk(hi, "R9 turns on after shutdown", int'(hi), 1);
        end

        // R6 / R7: undervoltage with hysteresis
        sup = 8'd85; tick(5);
        chk(hi, "R6 no trip at 85", int'(hi), 1);
        sup = 8'd82; tick(5);
        chk(hi, "R6 no trip at 82", int'(hi), 1);
        sup = 8'd81; tick(2);
        chk(!hi && !lo, "R7 lockout forces off", int'({hi, lo}), 0);
        sup = 8'd90; tick(10);
        chk(!hi && !lo, "R6 still locked at 90", int'({hi, lo}), 0);
        pwm = 1'b0; tick(5);
        chk(!hi && !lo, "R7 locked with pwm low", int'({hi, lo}), 0);
        sup = 8'd91;
        begin
            int gap = 0;
            for (int k = 0; k < 30; k++) begin
                @(negedge clk);
                if (lo) break;
                gap++;
            end
            chk(gap >= 5, "R9 gap after lockout", gap, 5);
            chk(lo, "R6 release above 90", int'(lo), 1);
        end
        gap_test(1'b1, 5, "R3 after lockout");

        // R10: reset mid-run
        rst_n = 1'b0;
        tick(1);
        chk(!hi && !lo, "R10 async reset", int'({hi, lo}), 0);
        rst_n = 1'b1;
        tick(1);
        chk(!hi && !lo, "R10 lockout active after reset", int'({hi, lo}), 0);
        tick(20);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule